// File: doc/BRIEF.md
# Translation Buffer Replacement Slot Chooser

This block decides which slot of a fully associative translation buffer takes the next mapping. It holds three status bits for every slot: present, referenced and pinned. It also keeps a running count of referenced slots. A fill request may name its slot outright. If it does not, the lowest-numbered empty slot is taken. When no slot is empty, a round-robin cursor walks the slots one per cycle, passes over pinned slots, and stops at the first unpinned one. If every slot other than the cursor's own is pinned, the highest-numbered slot is used as a fallback.

Requests arrive on a valid/ready stream. The chosen slot leaves on a second valid/ready stream. The mapping is committed into the status bits when the consumer accepts the result. While the result waits for `res_ready`, it stays put and no new request is taken. So back-pressure on the result side stalls the request side. Two plain control inputs mark a slot referenced (on a lookup hit) or clear a slot out (on an invalidation).

Top module: `tlb_victim_sel`

## Requirements
- R1: After reset no slot is present, the referenced count is 0, `req_ready` is 1 and `res_valid` is 0. The round-robin cursor is set so that the first walk begins at slot 0.
- R2: A request with `req_has_idx`=1 returns `req_idx` unchanged, as a binary slot number. This holds even when empty slots exist or that slot is pinned. The result appears one cycle after acceptance.
- R3: A request without an index returns the lowest-numbered slot whose present bit is 0, when one exists. The result appears one cycle after acceptance.
- R4: A request without an index, when all slots are present, examines slots one per cycle. It starts just after the cursor and wraps from ENTRIES-1 to 0. It returns the first slot whose pinned bit is 0. A victim found at distance j from the cursor is returned j+1 cycles after acceptance.
- R5: If the walk reaches the cursor slot without finding an unpinned slot, ENTRIES-1 is returned, ENTRIES+1 cycles after acceptance.
- R6: The cursor moves to the returned slot only when the walk of R4 finds a victim. Explicit picks, empty-slot picks and the fallback of R5 leave it where it is.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_idx` holds its value. `req_ready` is 0 from acceptance until the result is taken.
- R8: When a result is taken, that slot becomes present and not referenced. Its pinned bit takes the `req_lock` value that was captured at acceptance.
- R9: `mark_en` sets the referenced bit of a present, unreferenced slot and raises the count by 1. On an empty or already referenced slot it has no effect.
- R10: `inval_en` clears the present, referenced and pinned bits of the slot. The count drops by 1 if that slot was referenced.
- R11: A fill that overwrites a referenced slot lowers the count by 1.
- R12: In a cycle where a result is taken, `inval_en` and `mark_en` are ignored. When both are raised without a fill, only the invalidation acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request present |
| req_ready | output | 1 | Chooser idle and able to accept |
| req_has_idx | input | 1 | Request names its slot |
| req_idx | input | IDX_W | Named slot number |
| req_lock | input | 1 | Pin the filled slot |
| res_valid | output | 1 | Chosen slot available |
| res_ready | input | 1 | Consumer takes the chosen slot |
| res_idx | output | IDX_W | Chosen slot number |
| mark_en | input | 1 | Mark a slot referenced |
| mark_idx | input | IDX_W | Slot to mark |
| inval_en | input | 1 | Clear a slot out |
| inval_idx | input | IDX_W | Slot to clear |
| valid_mask | output | ENTRIES | Present bit per slot, bit i for slot i |
| used_count | output | CNT_W | Number of referenced slots |

## Verification
Requests are issued in several ways: with a named slot, with empty slots available, with a full buffer and scattered pins, and with every slot pinned. Comparing the returned slot and its latency against a reference model separates the three selection paths. It also exposes an off-by-one in the walk's start point or wrap. Random back-pressure checks that the result holds steady while it waits. Interleaved mark and invalidate traffic, including operations timed to land on a fill cycle, checks the referenced count and the priority among updates.

// File: rtl/tlb_victim_sel_pkg.sv
package tlb_victim_sel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_HOLD = 2'd2
  } sel_state_e;
endpackage

// File: rtl/tlbv_first_free.sv
module tlbv_first_free #(
  parameter int N   = 8,
  parameter int W   = $clog2(N)
) (
  input  logic [N-1:0] empty_vec,
  output logic         any_empty,
  output logic [W-1:0] first_idx
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    first_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (empty_vec[i]) first_idx = W'(i);
    end
  end
  assign any_empty = |empty_vec;
endmodule

// File: rtl/tlbv_status.sv
module tlbv_status #(
  parameter int N     = 8,
  parameter int W     = $clog2(N),
  parameter int CW    = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_en,
  input  logic [W-1:0]  fill_idx,
  input  logic          fill_lock,
  input  logic          mark_en,
  input  logic [W-1:0]  mark_idx,
  input  logic          inval_en,
  input  logic [W-1:0]  inval_idx,
  output logic [N-1:0]  valid_vec,
  output logic [N-1:0]  lock_vec,
  output logic [CW-1:0] used_cnt
);
  logic [N-1:0] valid_q, used_q, lock_q;
  logic [CW-1:0] cnt_q;
  logic do_inv, do_mark;

  // one update per cycle: fill, then invalidate, then mark (R12)
  assign do_inv  = inval_en && !fill_en;
  assign do_mark = mark_en && !fill_en && !inval_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      used_q  <= '0;
      lock_q  <= '0;
      cnt_q   <= '0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
      used_q[fill_idx]  <= 1'b0;
      lock_q[fill_idx]  <= fill_lock;
      if (used_q[fill_idx]) cnt_q <= cnt_q - 1'b1;
    end else if (do_inv) begin
      valid_q[inval_idx] <= 1'b0;
      used_q[inval_idx]  <= 1'b0;
      lock_q[inval_idx]  <= 1'b0;
      if (used_q[inval_idx]) cnt_q <= cnt_q - 1'b1;
    end else if (do_mark && valid_q[mark_idx] && !used_q[mark_idx]) begin
      used_q[mark_idx] <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_vec = valid_q;
  assign lock_vec  = lock_q;
  assign used_cnt  = cnt_q;

  // R9 R10 R11: counter tracks the referenced bits
  assert_count_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CW'($countones(used_q)));
  // R9: referenced only on present slots
  assert_used_implies_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q & ~valid_q) == '0);
  // R12: a fill-cycle invalidate leaves the filled state intact
  assert_fill_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && inval_en) |=> valid_q[$past(fill_idx)]);
endmodule

// File: rtl/tlbv_walker.sv
module tlbv_walker
  import tlb_victim_sel_pkg::*;
#(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_has_idx,
  input  logic [W-1:0] req_idx,
  input  logic         req_lock,
  input  logic         any_empty,
  input  logic [W-1:0] empty_idx,
  input  logic [N-1:0] lock_vec,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_idx,
  output logic         fill_en,
  output logic         fill_lock
);
  localparam logic [W-1:0] TOP_IDX = W'(N - 1);

  sel_state_e   state_q;
  logic [W-1:0] cursor_q, last_q, pick_q;
  logic         lock_q;

  function automatic logic [W-1:0] step(input logic [W-1:0] i);
    return (i == TOP_IDX) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cursor_q <= '0;
      last_q   <= TOP_IDX;
      pick_q   <= '0;
      lock_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          lock_q <= req_lock;
          if (req_has_idx) begin
            pick_q  <= req_idx;
            state_q <= ST_HOLD;
          end else if (any_empty) begin
            pick_q  <= empty_idx;
            state_q <= ST_HOLD;
          end else begin
            cursor_q <= step(last_q);
            state_q  <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (cursor_q == last_q) begin
            pick_q  <= TOP_IDX;
            state_q <= ST_HOLD;
          end else if (!lock_vec[cursor_q]) begin
            pick_q  <= cursor_q;
            last_q  <= cursor_q;
            state_q <= ST_HOLD;
          end else begin
            cursor_q <= step(cursor_q);
          end
        end
        ST_HOLD: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign res_valid = (state_q == ST_HOLD);
  assign res_idx   = pick_q;
  assign fill_en   = res_valid && res_ready;
  assign fill_lock = lock_q;

  // R7: result held under back-pressure
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_idx)));
  // R7: no acceptance while a result is pending
  assert_one_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));
  // R6: cursor moves only onto the slot being returned
  assert_cursor_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_q != $past(last_q)) |-> (res_valid && res_idx == last_q));
  // R5: walk back at cursor gives the fallback slot, cursor kept
  assert_fallback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WALK && cursor_q == last_q) |=> (res_idx == TOP_IDX && $stable(last_q)));
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_has_idx,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic               req_lock,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [IDX_W-1:0]   res_idx,
  input  logic               mark_en,
  input  logic [IDX_W-1:0]   mark_idx,
  input  logic               inval_en,
  input  logic [IDX_W-1:0]   inval_idx,
  output logic [ENTRIES-1:0] valid_mask,
  output logic [CNT_W-1:0]   used_count
);
  logic [ENTRIES-1:0] valid_vec, lock_vec;
  logic               any_empty, fill_en, fill_lock;
  logic [IDX_W-1:0]   empty_idx;

  tlbv_first_free #(.N(ENTRIES), .W(IDX_W)) u_free (
    .empty_vec (~valid_vec),
    .any_empty (any_empty),
    .first_idx (empty_idx)
  );

  tlbv_walker #(.N(ENTRIES), .W(IDX_W)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_has_idx (req_has_idx),
    .req_idx     (req_idx),
    .req_lock    (req_lock),
    .any_empty   (any_empty),
    .empty_idx   (empty_idx),
    .lock_vec    (lock_vec),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_idx     (res_idx),
    .fill_en     (fill_en),
    .fill_lock   (fill_lock)
  );

  tlbv_status #(.N(ENTRIES), .W(IDX_W), .CW(CNT_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en   (fill_en),
    .fill_idx  (res_idx),
    .fill_lock (fill_lock),
    .mark_en   (mark_en),
    .mark_idx  (mark_idx),
    .inval_en  (inval_en),
    .inval_idx (inval_idx),
    .valid_vec (valid_vec),
    .lock_vec  (lock_vec),
    .used_cnt  (used_count)
  );

  assign valid_mask = valid_vec;
endmodule

// File: tb/tlb_victim_sel_bench.sv
module tlb_victim_sel_bench;
  localparam int N = 8;
  localparam int W = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_has_idx = 0, req_lock = 0, res_ready = 0;
  logic mark_en = 0, inval_en = 0;
  logic [W-1:0] req_idx = '0, mark_idx = '0, inval_idx = '0;
  logic req_ready, res_valid;
  logic [W-1:0] res_idx;
  logic [N-1:0] valid_mask;
  logic [CW-1:0] used_count;

  int tests = 0, fails = 0;

  // reference model
  logic [N-1:0] m_valid = '0, m_used = '0, m_lock = '0;
  int m_last = N - 1;

  always #2 clk = ~clk;

  tlb_victim_sel #(.ENTRIES(N)) u_tlb_victim_sel (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_has_idx(req_has_idx),
    .req_idx(req_idx), .req_lock(req_lock),
    .res_valid(res_valid), .res_ready(res_ready), .res_idx(res_idx),
    .mark_en(mark_en), .mark_idx(mark_idx), .inval_en(inval_en), .inval_idx(inval_idx),
    .valid_mask(valid_mask), .used_count(used_count)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int m_count();
    return $countones(m_used);
  endfunction

  // expected slot, latency and whether the cursor moves
  function automatic void predict(input bit has, input int idx,
                                  output int e_idx, output int e_lat, output bit moves);
    int x;
    moves = 0;
    if (has) begin e_idx = idx; e_lat = 1; return; end
    for (int i = 0; i < N; i++)
      if (!m_valid[i]) begin e_idx = i; e_lat = 1; return; end
    x = m_last;
    for (int j = 1; j <= N; j++) begin
      x = (x + 1) % N;
      if (x == m_last) begin e_idx = N - 1; e_lat = N + 1; return; end
      if (!m_lock[x]) begin e_idx = x; e_lat = j + 1; moves = 1; return; end
    end
  endfunction

  task automatic check_state(input string rq);
    chk(valid_mask == m_valid, {rq, " mask"}, int'(valid_mask), int'(m_valid));
    chk(int'(used_count) == m_count(), {rq, " count"}, int'(used_count), m_count());
  endtask

  task automatic do_req(input bit has, input int idx, input bit lk, input int stall,
                        input bit side, input int side_idx);
    int e_idx, e_lat, lat, held;
    bit moves;
    predict(has, idx, e_idx, e_lat, moves);
    @(negedge clk);
    chk(req_ready, "R7 ready idle", req_ready, 1);
    req_valid = 1; req_has_idx = has; req_idx = W'(idx); req_lock = lk;
    @(negedge clk);
    req_valid = 0; req_has_idx = 0; req_lock = 0;
    lat = 1;
    while (!res_valid && lat < 40) begin
      chk(!req_ready, "R7 busy", req_ready, 0);
      @(negedge clk); lat++;
    end
    chk(int'(res_idx) == e_idx,
        has ? "R2 explicit idx" : (e_lat == 1 ? "R3 free idx" : (e_lat == N + 1 ? "R5 fallback idx" : "R4 walk idx")),
        int'(res_idx), e_idx);
    chk(lat == e_lat, has ? "R2 latency" : (e_lat == 1 ? "R3 latency" : "R4 R5 latency"), lat, e_lat);
    held = int'(res_idx);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(res_valid && int'(res_idx) == held, "R7 hold", int'(res_idx), held);
    end
    res_ready = 1;
    if (side) begin inval_en = 1; inval_idx = W'(side_idx); mark_en = 1; mark_idx = W'(side_idx); end
    @(negedge clk);
    res_ready = 0; inval_en = 0; mark_en = 0;
    chk(!res_valid, "R7 released", res_valid, 0);
    m_valid[e_idx] = 1; m_used[e_idx] = 0; m_lock[e_idx] = lk;
    if (moves) m_last = e_idx;
    check_state(side ? "R12 fill priority" : "R8 R11 commit");
  endtask

  task automatic do_mark(input int idx);
    @(negedge clk);
    mark_en = 1; mark_idx = W'(idx);
    @(negedge clk);
    mark_en = 0;
    if (m_valid[idx]) m_used[idx] = 1;
    check_state("R9 mark");
  endtask

  task automatic do_inval(input int idx, input bit with_mark);
    @(negedge clk);
    inval_en = 1; inval_idx = W'(idx);
    if (with_mark) begin mark_en = 1; mark_idx = W'(idx); end
    @(negedge clk);
    inval_en = 0; mark_en = 0;
    m_valid[idx] = 0; m_used[idx] = 0; m_lock[idx] = 0;
    check_state(with_mark ? "R12 inval over mark" : "R10 inval");
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(valid_mask == '0, "R1 mask", int'(valid_mask), 0);
    chk(used_count == '0, "R1 count", int'(used_count), 0);
    chk(req_ready && !res_valid, "R1 handshake", {req_ready, res_valid}, 2);
    do_mark(3);                       // R9: empty slot, no effect
    // fill all slots from empty; pin 1 and 2
    for (int i = 0; i < N; i++) do_req(0, 0, (i == 1 || i == 2), i % 3, 0, 0);
    do_mark(4); do_mark(4); do_mark(5);
    // R4: first walk starts at slot 0
    do_req(0, 0, 0, 0, 0, 0);
    // R4: skips pinned 1,2
    do_req(0, 0, 0, 1, 0, 0);
    // R2: explicit onto a pinned slot; R6: cursor unmoved
    do_req(1, 2, 1, 0, 0, 0);
    do_req(0, 0, 0, 0, 0, 0);
    // R11: overwrite referenced slot 5
    do_req(1, 5, 0, 0, 0, 0);
    // R12: side ops during fill, then inval over mark
    do_mark(6);
    do_req(1, 0, 0, 2, 1, 6);
    do_inval(6, 1);
    // R5: everything pinned
    for (int i = 0; i < N; i++) do_inval(i, 0);
    for (int i = 0; i < N; i++) do_req(0, 0, 1, 0, 0, 0);
    do_req(0, 0, 1, 0, 0, 0);
    do_inval(0, 0);
    do_req(0, 0, 0, 0, 0, 0);           // R3 free again
    do_req(0, 0, 0, 0, 0, 0);           // R6: walk from unchanged cursor
    // random traffic
    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 5)
        do_req(($urandom % 4) == 0, int'($urandom % N), ($urandom % 3) == 0,
               int'($urandom % 3), 0, 0);
      else if (r < 7) do_mark(int'($urandom % N));
      else if (r < 9) do_inval(int'($urandom % N), 0);
      else do_inval(int'($urandom % N), 1);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule